// File: doc/BRIEF.md
# Page Write Load Controller

This block handles the write side of a byte-alterable nonvolatile memory. The memory is reached through active-low chip-select, write-strobe and output-enable lines, and a fast system clock samples those lines. A write strobe is the interval during which chip-select and write-strobe are both low while output-enable is high. The block takes the address when that interval opens and the data from its last active cycle. Each accepted byte goes into a page buffer.

The first byte of an operation locks the page, which is the address bits above the in-page offset. Every later byte must fall in that same page. If no further byte arrives within a byte-load window, an internal programming cycle begins and `busy` goes high for a programmable number of cycles. When that cycle ends, the bytes that were loaded are copied into the behavioural storage array and `commit` pulses for one cycle. Bytes of the page that were not loaded keep their old contents. A separate read port shows the array contents, so that the effect of each write can be seen.

Top module: `page_load_ctrl`

## Requirements
- R1: A write strobe exists only in cycles where `ce_n`=0, `we_n`=0 and `oe_n`=1. Activity with `oe_n` low, `we_n` high or `ce_n` high loads nothing and starts no programming cycle.
- R2: The address of a byte load is the one on `addr` in the first clock cycle in which the strobe condition holds. This is the later of the two falling edges. The data is the one on `din` in the last such cycle, just before the earlier of the two rising edges.
- R3: A strobe that is active for fewer than MIN_PW consecutive sampled cycles is discarded.
- R4: Address bits [OFF_W-1:0] (default [6:0], so 128 bytes per page) select the byte within the page. The first accepted byte of an operation locks bits [ADDR_W-1:OFF_W] as the page.
- R5: A later byte whose page bits differ from the locked page is not loaded. `page_err` is high for exactly one cycle, starting at the clock edge that ends that strobe.
- R6: The internal programming cycle starts, and `busy` rises, BLC_CYC clock edges after the edge that first saw the strobe of the last accepted byte. A new accepted byte that ends before that edge restarts the window.
- R7: `busy` stays high for exactly TWC_CYC cycles. When it falls, `commit` is high for one cycle and the array already holds the new data. At no other time does the array change.
- R8: A strobe that begins while `busy` is high loads nothing.
- R9: Only bytes that were actually loaded are written into the array, and the other bytes of the page keep their contents. If the same offset is loaded twice, the later data wins.
- R10: After synchronous reset, `busy`, `commit` and `page_err` are low and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobe lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable; a low level inhibits writing |
| addr | input | ADDR_W | Byte address; upper bits are the page, lower OFF_W bits the offset |
| din | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address into the storage array |
| rd_data | output | DATA_W | Array contents at `rd_addr` (combinational) |
| busy | output | 1 | Internal programming cycle in progress |
| commit | output | 1 | One-cycle pulse when the loaded bytes have been written to the array |
| page_err | output | 1 | One-cycle pulse when a byte is refused for a page mismatch |

## Verification
A wrong window or cycle counter appears first as a `busy` edge that comes one or more cycles off. A lost or stale page lock shows up as a `page_err` pulse at the end of the offending strobe, or as a missing one. A corrupt buffer entry or valid flag stays hidden until `commit`, and then appears as a wrong byte on `rd_data` in the cycle straight after that pulse. For this reason `busy`, `commit`, `page_err` and `rd_data` are compared every cycle against a behavioural model, and the array is also read back with fixed expected bytes.

// File: rtl/plc_pkg.sv
package plc_pkg;

    localparam int DEF_ADDR_W = 9;
    localparam int DEF_OFF_W  = 7;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_BLC    = 20;
    localparam int DEF_TWC    = 40;
    localparam int DEF_MIN_PW = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ld_state_e;

    // bits needed to hold the value n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/plc_strobe_capture.sv
module plc_strobe_capture
    import plc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int AGE_W  = 5,
    parameter int MIN_PW = DEF_MIN_PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              busy,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic [AGE_W-1:0]  ld_age
);

    logic              act;
    logic              act_q;
    logic              ok_q;
    logic [AGE_W-1:0]  run_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              long_enough;

    assign act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            ok_q   <= 1'b0;
            run_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= act;
            if (act) begin
                data_q <= din;
                if (!act_q) begin
                    addr_q <= addr;
                    run_q  <= AGE_W'(1);
                    ok_q   <= !busy;
                end else if (run_q != '1) begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    generate
        if (MIN_PW <= 1) begin : g_nofilt
            assign long_enough = 1'b1;
        end else begin : g_filt
            assign long_enough = (run_q >= AGE_W'(MIN_PW));
        end
    endgenerate

    assign ld_vld  = act_q && !act && ok_q && long_enough;
    assign ld_addr = addr_q;
    assign ld_data = data_q;
    assign ld_age  = run_q;

endmodule

// File: rtl/plc_page_buffer.sv
module plc_page_buffer
    import plc_pkg::*;
#(
    parameter int OFF_W  = DEF_OFF_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int NBYTE = 2 ** OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    output logic [DATA_W-1:0] bdata [NBYTE],
    output logic [NBYTE-1:0]  bvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid <= '0;
            for (int i = 0; i < NBYTE; i++) bdata[i] <= '0;
        end else if (clr) begin
            bvalid <= '0;
        end else if (wr_en) begin
            bvalid[wr_off] <= 1'b1;
            bdata[wr_off]  <= wr_data;
        end
    end

endmodule

// File: rtl/plc_nvm_array.sv
module plc_nvm_array
    import plc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OFF_W  = DEF_OFF_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int NBYTE  = 2 ** OFF_W,
    localparam int DEPTH  = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] bdata [NBYTE],
    input  logic [NBYTE-1:0]  bvalid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit_en) begin
            for (int o = 0; o < NBYTE; o++) begin
                if (bvalid[o]) mem[{page, OFF_W'(o)}] <= bdata[o];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int OFF_W   = DEF_OFF_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int BLC_CYC = DEF_BLC,
    parameter int TWC_CYC = DEF_TWC,
    parameter int MIN_PW  = DEF_MIN_PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              commit,
    output logic              page_err
);

    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int NBYTE  = 2 ** OFF_W;
    localparam int WIN_W  = cnt_w(BLC_CYC);
    localparam int TMR_W  = cnt_w(TWC_CYC);

    ld_state_e         state_q;
    logic [PAGE_W-1:0] page_q;
    logic [WIN_W-1:0]  win_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              commit_q;
    logic              err_q;

    logic              ld_vld;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic [WIN_W-1:0]  ld_age;
    logic [PAGE_W-1:0] ld_page;
    logic              same_page;
    logic              buf_wr;
    logic              prog_done;
    logic [DATA_W-1:0] bdata [NBYTE];
    logic [NBYTE-1:0]  bvalid;

    plc_strobe_capture #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_W(WIN_W), .MIN_PW(MIN_PW)
    ) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .busy(busy),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data), .ld_age(ld_age)
    );

    assign ld_page   = ld_addr[ADDR_W-1:OFF_W];
    assign same_page = (ld_page == page_q);
    assign buf_wr    = ld_vld && ((state_q == ST_IDLE) ||
                                  (state_q == ST_LOAD && same_page));
    assign prog_done = (state_q == ST_PROG) && (tmr_q == TMR_W'(TWC_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            page_q   <= '0;
            win_q    <= '0;
            tmr_q    <= '0;
            commit_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            err_q    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ld_vld) begin
                        page_q  <= ld_page;
                        win_q   <= ld_age;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (ld_vld) begin
                        if (same_page) win_q <= ld_age;
                        else           err_q <= 1'b1;
                    end else if (win_q >= WIN_W'(BLC_CYC - 1)) begin
                        state_q <= ST_PROG;
                        tmr_q   <= '0;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prog_done) begin
                        state_q  <= ST_IDLE;
                        commit_q <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    plc_page_buffer #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst(rst), .wr_en(buf_wr), .wr_off(ld_addr[OFF_W-1:0]),
        .wr_data(ld_data), .clr(prog_done), .bdata(bdata), .bvalid(bvalid)
    );

    plc_nvm_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst(rst), .commit_en(prog_done), .page(page_q),
        .bdata(bdata), .bvalid(bvalid), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign busy     = (state_q == ST_PROG);
    assign commit   = commit_q;
    assign page_err = err_q;

endmodule

// File: rtl/plc_chk.sv
module plc_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              commit,
    input logic              page_err,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);

    // R5
    err_outside_prog_chk: assert property (@(posedge clk) disable iff (rst)
        page_err |-> !busy);

    // R5
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        page_err |=> !page_err);

    // R7
    commit_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> commit);

    // R7
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy && $past(busy));

    // R7
    array_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(rd_addr) && !commit) |-> $stable(rd_data));

    // R6
    busy_start_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !commit && !page_err);

endmodule

bind page_load_ctrl plc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .commit(commit),
    .page_err(page_err), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb;

    localparam int AW  = 9;
    localparam int OW  = 7;
    localparam int DW  = 8;
    localparam int BLC = 20;
    localparam int TWC = 40;
    localparam int MPW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy, commit, page_err;

    int    vecs = 0;
    int    errs = 0;
    int    cycles = 0;
    string phase = "R10";

    always #5 clk = ~clk;

    page_load_ctrl #(
        .ADDR_W(AW), .OFF_W(OW), .DATA_W(DW),
        .BLC_CYC(BLC), .TWC_CYC(TWC), .MIN_PW(MPW)
    ) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .commit(commit), .page_err(page_err)
    );

    // behavioural reference model
    bit      m_pact;
    int      m_len;
    bit      m_ok;
    int      m_addr_l, m_data_l;
    int      m_mode, m_win, m_tmr, m_page;
    bit      m_commit, m_err;
    byte     m_buf [int];
    byte     m_mem [int];

    always @(posedge clk) begin
        bit sact, ev;
        int ev_a, ev_d, ev_len;
        if (rst) begin
            m_pact = 0; m_len = 0; m_ok = 0; m_addr_l = 0; m_data_l = 0;
            m_mode = 0; m_win = 0; m_tmr = 0; m_page = 0;
            m_commit = 0; m_err = 0;
            m_buf.delete(); m_mem.delete();
        end else begin
            sact = !ce_n && !we_n && oe_n;
            ev = (!sact && m_pact && m_len >= MPW && m_ok);
            ev_a = m_addr_l; ev_d = m_data_l; ev_len = m_len;
            if (sact) begin
                m_data_l = int'(din);
                if (!m_pact) begin
                    m_addr_l = int'(addr); m_len = 1; m_ok = (m_mode != 2);
                end else m_len++;
            end
            m_pact = sact;
            m_commit = 0; m_err = 0;
            case (m_mode)
                0: if (ev) begin
                    m_page = ev_a >> OW;
                    m_buf[ev_a % (1 << OW)] = byte'(ev_d);
                    m_win = ev_len; m_mode = 1;
                end
                1: if (ev) begin
                    if ((ev_a >> OW) == m_page) begin
                        m_buf[ev_a % (1 << OW)] = byte'(ev_d);
                        m_win = ev_len;
                    end else m_err = 1;
                end else if (m_win >= BLC - 1) begin
                    m_mode = 2; m_tmr = 0;
                end else m_win++;
                default: if (m_tmr == TWC - 1) begin
                    foreach (m_buf[o]) m_mem[m_page * (1 << OW) + o] = m_buf[o];
                    m_buf.delete();
                    m_mode = 0; m_commit = 1;
                end else m_tmr++;
            endcase
        end
    end

    // per-cycle comparison, well after the edge
    always @(posedge clk) begin
        byte exp_rd;
        #3;
        exp_rd = m_mem.exists(int'(rd_addr)) ? m_mem[int'(rd_addr)] : 8'h00;
        vecs++;
        if (busy !== (m_mode == 2)) begin
            errs++; $display("FAIL %s busy act=%b exp=%b", phase, busy, (m_mode == 2));
        end
        if (commit !== m_commit) begin
            errs++; $display("FAIL %s commit act=%b exp=%b", phase, commit, m_commit);
        end
        if (page_err !== m_err) begin
            errs++; $display("FAIL %s page_err act=%b exp=%b", phase, page_err, m_err);
        end
        if (rd_data !== exp_rd) begin
            errs++; $display("FAIL %s rd_data act=%h exp=%h", phase, rd_data, exp_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int w, input logic oe_lvl);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lvl;
        repeat (w) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '1; din = 8'h5A;
    endtask

    task automatic check_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                            input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        vecs++;
        if (rd_data !== exp) begin
            errs++;
            $display("FAIL %s read @%h act=%h exp=%h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        // R10: reset state
        idle(5);
        rst = 1'b0;
        idle(2);
        check_rd(9'h000, 8'h00, "R10");
        check_rd(9'h0FF, 8'h00, "R10");

        // R1: output enable low inhibits the write
        phase = "R1";
        strobe(9'h085, 8'h11, 3, 1'b0);
        idle(BLC + TWC);
        check_rd(9'h085, 8'h00, "R1");

        // R3: one-cycle glitch is discarded
        phase = "R3";
        strobe(9'h085, 8'h22, 1, 1'b1);
        idle(BLC + TWC);
        check_rd(9'h085, 8'h00, "R3");

        // R2: chip select falls first, write strobe later; data changes inside
        phase = "R2";
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 9'h1AA; din = 8'h99;
        @(negedge clk); we_n = 1'b0; addr = 9'h085; din = 8'h77;
        @(negedge clk); addr = 9'h100; din = 8'hA5;
        @(negedge clk); we_n = 1'b1; addr = 9'h1FF; din = 8'h55;
        @(negedge clk); ce_n = 1'b1;

        // R4: more bytes in the same page, including the top offset
        phase = "R4";
        strobe(9'h086, 8'h3C, 3, 1'b1);
        strobe(9'h0FF, 8'hE1, 2, 1'b1);

        // R5: foreign page refused
        phase = "R5";
        strobe(9'h106, 8'hBB, 3, 1'b1);

        // R9: reload of an offset, later value wins
        phase = "R9";
        strobe(9'h086, 8'h4D, 2, 1'b1);

        // R6 then R7: window expiry and programming
        phase = "R6";
        idle(BLC + 2);
        phase = "R7";
        idle(TWC + 2);
        check_rd(9'h085, 8'hA5, "R2");
        check_rd(9'h0FF, 8'hE1, "R4");
        check_rd(9'h086, 8'h4D, "R9");
        check_rd(9'h087, 8'h00, "R9");
        check_rd(9'h106, 8'h00, "R5");
        check_rd(9'h080, 8'h00, "R7");

        // R8: strobe during busy is ignored; R9 old page bytes kept
        phase = "R8";
        strobe(9'h090, 8'h66, 3, 1'b1);
        idle(BLC + 2);
        strobe(9'h091, 8'h77, 3, 1'b1);
        idle(TWC + 5);
        check_rd(9'h090, 8'h66, "R8");
        check_rd(9'h091, 8'h00, "R8");
        check_rd(9'h085, 8'hA5, "R9");
        check_rd(9'h0FF, 8'hE1, "R9");

        // R6: second byte arrives before the window closes and extends it
        phase = "R6";
        strobe(9'h100, 8'h12, 3, 1'b1);
        idle(BLC - 10);
        strobe(9'h101, 8'h34, 3, 1'b1);
        idle(BLC + TWC + 5);
        check_rd(9'h100, 8'h12, "R6");
        check_rd(9'h101, 8'h34, "R6");
        check_rd(9'h090, 8'h66, "R9");

        // R10: reset clears the array again
        phase = "R10";
        @(negedge clk); rst = 1'b1;
        idle(3);
        rst = 1'b0;
        check_rd(9'h100, 8'h00, "R10");
        check_rd(9'h085, 8'h00, "R10");

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule